// File: doc/BRIEF.md
# Per-Processor Private Interrupt Redistributor

This block keeps the interrupt state of one processor's 32 private interrupts. IDs 0 to 15 are software-generated. IDs 16 to 31 come from private peripheral lines. For each interrupt the block stores an enable bit, a pending bit, an active bit, a group bit and an 8-bit priority. It also holds two 32-bit configuration words. All of this is reached through a 32-bit register port.

From the stored state the block drives two request lines toward the processor, `irq` and `fiq`. The priority-mask and acknowledge machinery lives in a separate CPU-interface block. That block provides the two group-enable inputs used here.

The address space holds a row of redistributors placed back to back. Each redistributor has a 64 KiB control frame followed by a 64 KiB private-interrupt frame. This instance answers only the slot whose index equals its `SELF_ID` parameter. Within that slot it answers only in the private-interrupt frame. Offsets in that frame, relative to its start: group `0x00`; enable set/clear `0x10`/`0x14`; pending set/clear `0x20`/`0x24`; active set/clear `0x30`/`0x34`; priority words `0x40`..`0x5C`; configuration words `0x80` and `0x84`.

Top module: `pirq_redist`

## Requirements
- R1: For each of the enable, pending and active bitmaps, writing 1 to a bit at the set address sets that bit, and writing 1 at the clear address clears it. Writing 0 at either address leaves the bit unchanged.
- R2: A read from the set address or the clear address of a pair returns the same current bitmap.
- R3: An interrupt is forwarded when it is pending, enabled and not active. `irq` is high when a forwarded interrupt has group bit 1 and `grp1_en` is high.
- R4: `fiq` is high when a forwarded interrupt has group bit 0 and `grp0_en` is high.
- R5: When nothing is forwarded, both `irq` and `fiq` are low. An active interrupt never drives either line.
- R6: Priority word k (offset `0x40+4k`) holds interrupt 4k+j in bits 8j+7:8j. Each word reads back what was written, and writing one word leaves the others unchanged.
- R7: The group register and both configuration registers are plain read/write storage.
- R8: The redistributor index is the address divided by 128 KiB. An access to any index other than `SELF_ID` has no effect, reads zero and raises no error.
- R9: Within its own slot, an access to the control frame or to an unmapped offset of the private frame is ignored and reads zero. Such an access pulses `bus_err` for one cycle.
- R10: The two low address bits are dropped: an unaligned address hits the word that contains it.
- R11: A rising edge on `ppi_level[i]` sets pending bit 16+i, and a falling edge clears it. A level held steady does not set the bit again.
- R12: `sgi_set` sets pending bit `sgi_id` and `sgi_clr` clears it. If both are high in the same cycle, the clear wins.
- R13: `bus_rdata` and `bus_err` are valid in the cycle after the access strobe, and `irq`/`fiq` follow a state change at that same clock edge. After reset all state is zero and both lines are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after `bus_rd` |
| bus_err | output | 1 | Unmapped access in own slot, one-cycle pulse |
| ppi_level | input | NUM_PPI | Peripheral interrupt lines |
| sgi_id | input | SGI_W | Software interrupt number |
| sgi_set | input | 1 | Set pending for `sgi_id` |
| sgi_clr | input | 1 | Clear pending for `sgi_id` |
| grp0_en | input | 1 | Group 0 signalling enable |
| grp1_en | input | 1 | Group 1 signalling enable |
| irq | output | 1 | Group 1 request line |
| fiq | output | 1 | Group 0 request line |

## Verification
The signalling logic is driven through a series of combinations:
- A pending interrupt that is not enabled.
- An enabled interrupt that is not pending.
- A pending, enabled interrupt that is then made active.
- Group bits flipped between the two lines.
- One interrupt of each group forwarded at once.

Together these separate the three-term forwarding condition from any two-term shortcut, and check that group steering picks the correct line. Set and clear writes carrying zero bits show that only 1 bits act. Reads through the opposite address of each pair show that the pair shares a single bitmap.

For addressing, the bench covers a foreign slot, the control frame, an unmapped offset and an unaligned address, which separates the index, frame and offset decode. Edge-versus-level behaviour of the peripheral lines is exposed by clearing a bit in software while its line stays high.

// File: rtl/pirq_pkg.sv
package pirq_pkg;

   typedef enum logic [3:0] {
      SEL_NONE,
      SEL_GRP,
      SEL_EN_SET,
      SEL_EN_CLR,
      SEL_PN_SET,
      SEL_PN_CLR,
      SEL_AC_SET,
      SEL_AC_CLR,
      SEL_PRIO,
      SEL_CFG0,
      SEL_CFG1
   } reg_sel_e;

   // Offsets inside the private-interrupt frame
   localparam int unsigned OFF_GRP    = 32'h00;
   localparam int unsigned OFF_EN_SET = 32'h10;
   localparam int unsigned OFF_EN_CLR = 32'h14;
   localparam int unsigned OFF_PN_SET = 32'h20;
   localparam int unsigned OFF_PN_CLR = 32'h24;
   localparam int unsigned OFF_AC_SET = 32'h30;
   localparam int unsigned OFF_AC_CLR = 32'h34;
   localparam int unsigned OFF_PRIO   = 32'h40;
   localparam int unsigned OFF_CFG0   = 32'h80;
   localparam int unsigned OFF_CFG1   = 32'h84;

endpackage

// File: rtl/pirq_addr_dec.sv
module pirq_addr_dec
   import pirq_pkg::*;
#(
   parameter int ADDR_W   = 24,
   parameter int FRAME_LG = 16,
   parameter int NUM_INT  = 32,
   parameter int SELF_ID  = 0,
   localparam int SPAN_LG = FRAME_LG + 1,
   localparam int IDX_W   = ADDR_W - SPAN_LG,
   localparam int PW_W    = $clog2(NUM_INT / 4)
) (
   input  logic [ADDR_W-1:0] addr,
   output reg_sel_e          sel,
   output logic [PW_W-1:0]   prio_word,
   output logic              mine,
   output logic              bad
);

   if (IDX_W < 1) begin : g_chk_addr
      $error("ADDR_W must exceed the span of one redistributor");
   end
   if (FRAME_LG < 8) begin : g_chk_frame
      $error("frame too small for the register layout");
   end
   if ((OFF_PRIO % NUM_INT) != 0) begin : g_chk_align
      $error("priority block must be aligned to its size");
   end

   logic [IDX_W-1:0]    idx;
   logic                in_priv;
   logic [FRAME_LG-1:0] off;
   int unsigned         off_w;

   assign idx     = addr[ADDR_W-1:SPAN_LG];
   assign in_priv = addr[FRAME_LG];
   assign off     = {addr[FRAME_LG-1:2], 2'b00};
   assign off_w   = 32'(off);
   assign mine    = (idx == IDX_W'(SELF_ID));

   always_comb begin
      sel       = SEL_NONE;
      prio_word = off[PW_W+1:2];
      if (in_priv) begin
         if (off_w >= OFF_PRIO && off_w < OFF_PRIO + NUM_INT) sel = SEL_PRIO;
         else if (off_w == OFF_GRP)    sel = SEL_GRP;
         else if (off_w == OFF_EN_SET) sel = SEL_EN_SET;
         else if (off_w == OFF_EN_CLR) sel = SEL_EN_CLR;
         else if (off_w == OFF_PN_SET) sel = SEL_PN_SET;
         else if (off_w == OFF_PN_CLR) sel = SEL_PN_CLR;
         else if (off_w == OFF_AC_SET) sel = SEL_AC_SET;
         else if (off_w == OFF_AC_CLR) sel = SEL_AC_CLR;
         else if (off_w == OFF_CFG0)   sel = SEL_CFG0;
         else if (off_w == OFF_CFG1)   sel = SEL_CFG1;
      end
   end

   assign bad = mine && (sel == SEL_NONE);

endmodule

// File: rtl/pirq_bitmaps.sv
module pirq_bitmaps
   import pirq_pkg::*;
#(
   parameter int NUM_SGI = 16,
   parameter int NUM_PPI = 16,
   localparam int NUM_INT = NUM_SGI + NUM_PPI,
   localparam int SGI_W   = $clog2(NUM_SGI)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr,
   input  reg_sel_e           sel,
   input  logic [NUM_INT-1:0] wdata,
   input  logic [NUM_PPI-1:0] ppi_level,
   input  logic [SGI_W-1:0]   sgi_id,
   input  logic               sgi_set,
   input  logic               sgi_clr,
   output logic [NUM_INT-1:0] grp,
   output logic [NUM_INT-1:0] en,
   output logic [NUM_INT-1:0] pend,
   output logic [NUM_INT-1:0] act
);

   logic [NUM_PPI-1:0] ppi_q;
   logic [NUM_PPI-1:0] ppi_rise, ppi_fall;
   logic [NUM_INT-1:0] grp_n, en_n, pend_n, act_n;

   assign ppi_rise = ppi_level & ~ppi_q;
   assign ppi_fall = ~ppi_level & ppi_q;

   always_comb begin
      grp_n  = grp;
      en_n   = en;
      pend_n = pend;
      act_n  = act;
      if (wr) begin
         unique case (sel)
            SEL_GRP:    grp_n  = wdata;
            SEL_EN_SET: en_n   = en | wdata;
            SEL_EN_CLR: en_n   = en & ~wdata;
            SEL_PN_SET: pend_n = pend | wdata;
            SEL_PN_CLR: pend_n = pend & ~wdata;
            SEL_AC_SET: act_n  = act | wdata;
            SEL_AC_CLR: act_n  = act & ~wdata;
            default: ;
         endcase
      end
      // line events take effect after the register write
      if (sgi_set) pend_n[sgi_id] = 1'b1;
      if (sgi_clr) pend_n[sgi_id] = 1'b0;
      for (int i = 0; i < NUM_PPI; i++) begin
         if (ppi_rise[i]) pend_n[NUM_SGI+i] = 1'b1;
         if (ppi_fall[i]) pend_n[NUM_SGI+i] = 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ppi_q <= '0;
         grp   <= '0;
         en    <= '0;
         pend  <= '0;
         act   <= '0;
      end else begin
         ppi_q <= ppi_level;
         grp   <= grp_n;
         en    <= en_n;
         pend  <= pend_n;
         act   <= act_n;
      end
   end

endmodule

// File: rtl/pirq_prio_cfg.sv
module pirq_prio_cfg
   import pirq_pkg::*;
#(
   parameter int NUM_INT = 32,
   localparam int NUM_W  = NUM_INT / 4,
   localparam int PW_W   = $clog2(NUM_W)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wr,
   input  reg_sel_e        sel,
   input  logic [PW_W-1:0] prio_word,
   input  logic [31:0]     wdata,
   output logic [31:0]     prio_rd,
   output logic [31:0]     cfg0,
   output logic [31:0]     cfg1
);

   logic [31:0] words [NUM_W];

   for (genvar w = 0; w < NUM_W; w++) begin : g_word
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            words[w] <= '0;
         else if (wr && sel == SEL_PRIO && prio_word == PW_W'(w))
            words[w] <= wdata;
      end
   end

   assign prio_rd = words[prio_word];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg0 <= '0;
         cfg1 <= '0;
      end else if (wr) begin
         if (sel == SEL_CFG0) cfg0 <= wdata;
         if (sel == SEL_CFG1) cfg1 <= wdata;
      end
   end

endmodule

// File: rtl/pirq_forward.sv
module pirq_forward #(
   parameter int NUM_INT = 32,
   parameter bit REG_OUT = 1'b0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_INT-1:0] grp,
   input  logic [NUM_INT-1:0] en,
   input  logic [NUM_INT-1:0] pend,
   input  logic [NUM_INT-1:0] act,
   input  logic               grp0_en,
   input  logic               grp1_en,
   output logic               irq,
   output logic               fiq
);

   logic [NUM_INT-1:0] fwd;
   logic               irq_c, fiq_c;

   assign fwd   = pend & en & ~act;
   assign irq_c = (|(fwd & grp))  && grp1_en;
   assign fiq_c = (|(fwd & ~grp)) && grp0_en;

   if (REG_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            irq <= 1'b0;
            fiq <= 1'b0;
         end else begin
            irq <= irq_c;
            fiq <= fiq_c;
         end
      end
   end else begin : g_comb
      assign irq = irq_c;
      assign fiq = fiq_c;
   end

endmodule

// File: rtl/pirq_redist.sv
module pirq_redist
   import pirq_pkg::*;
#(
   parameter int ADDR_W   = 24,
   parameter int FRAME_LG = 16,
   parameter int NUM_SGI  = 16,
   parameter int NUM_PPI  = 16,
   parameter int SELF_ID  = 0,
   parameter bit REG_OUT  = 1'b0,
   localparam int NUM_INT = NUM_SGI + NUM_PPI,
   localparam int SGI_W   = $clog2(NUM_SGI),
   localparam int PW_W    = $clog2(NUM_INT / 4)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [ADDR_W-1:0]  bus_addr,
   input  logic               bus_wr,
   input  logic               bus_rd,
   input  logic [31:0]        bus_wdata,
   output logic [31:0]        bus_rdata,
   output logic               bus_err,
   input  logic [NUM_PPI-1:0] ppi_level,
   input  logic [SGI_W-1:0]   sgi_id,
   input  logic               sgi_set,
   input  logic               sgi_clr,
   input  logic               grp0_en,
   input  logic               grp1_en,
   output logic               irq,
   output logic               fiq
);

   if (NUM_INT != 32) begin : g_chk_count
      $error("bitmaps are one 32-bit word: NUM_SGI + NUM_PPI must be 32");
   end

   reg_sel_e          dec_sel, sel;
   logic [PW_W-1:0]   prio_word;
   logic              mine, bad;
   logic [NUM_INT-1:0] grp_map, en_map, pend_map, act_map;
   logic [31:0]       prio_rd, cfg0, cfg1, rd_mux;

   pirq_addr_dec #(
      .ADDR_W(ADDR_W), .FRAME_LG(FRAME_LG), .NUM_INT(NUM_INT), .SELF_ID(SELF_ID)
   ) u_dec (
      .addr(bus_addr), .sel(dec_sel), .prio_word(prio_word), .mine(mine), .bad(bad)
   );

   assign sel = mine ? dec_sel : SEL_NONE;

   pirq_bitmaps #(.NUM_SGI(NUM_SGI), .NUM_PPI(NUM_PPI)) u_maps (
      .clk(clk), .rst_n(rst_n), .wr(bus_wr), .sel(sel), .wdata(bus_wdata),
      .ppi_level(ppi_level), .sgi_id(sgi_id), .sgi_set(sgi_set), .sgi_clr(sgi_clr),
      .grp(grp_map), .en(en_map), .pend(pend_map), .act(act_map)
   );

   pirq_prio_cfg #(.NUM_INT(NUM_INT)) u_prio (
      .clk(clk), .rst_n(rst_n), .wr(bus_wr), .sel(sel), .prio_word(prio_word),
      .wdata(bus_wdata), .prio_rd(prio_rd), .cfg0(cfg0), .cfg1(cfg1)
   );

   pirq_forward #(.NUM_INT(NUM_INT), .REG_OUT(REG_OUT)) u_fwd (
      .clk(clk), .rst_n(rst_n), .grp(grp_map), .en(en_map), .pend(pend_map),
      .act(act_map), .grp0_en(grp0_en), .grp1_en(grp1_en), .irq(irq), .fiq(fiq)
   );

   always_comb begin
      unique case (sel)
         SEL_GRP:                rd_mux = grp_map;
         SEL_EN_SET, SEL_EN_CLR: rd_mux = en_map;
         SEL_PN_SET, SEL_PN_CLR: rd_mux = pend_map;
         SEL_AC_SET, SEL_AC_CLR: rd_mux = act_map;
         SEL_PRIO:               rd_mux = prio_rd;
         SEL_CFG0:               rd_mux = cfg0;
         SEL_CFG1:               rd_mux = cfg1;
         default:                rd_mux = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bus_rdata <= '0;
         bus_err   <= 1'b0;
      end else begin
         bus_err <= (bus_wr || bus_rd) && bad;
         if (bus_rd) bus_rdata <= rd_mux;
      end
   end

endmodule

// File: rtl/pirq_redist_chk.sv
module pirq_redist_chk #(
   parameter int NUM_SGI = 16,
   parameter int NUM_PPI = 16,
   localparam int NUM_INT = NUM_SGI + NUM_PPI
) (
   input logic               clk,
   input logic               rst_n,
   input logic               bus_wr,
   input logic               bus_rd,
   input logic               bus_err,
   input logic [31:0]        bus_rdata,
   input logic [NUM_PPI-1:0] ppi_level,
   input logic               grp0_en,
   input logic               grp1_en,
   input logic               irq,
   input logic               fiq,
   input logic [NUM_INT-1:0] en,
   input logic [NUM_INT-1:0] pend,
   input logic [NUM_INT-1:0] act
);

   a_r5_idle_lines_low: assert property (@(posedge clk) disable iff (!rst_n)
      (~|(pend & en & ~act)) |-> (!irq && !fiq));

   a_r3_irq_needs_grp1: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> grp1_en);

   a_r4_fiq_needs_grp0: assert property (@(posedge clk) disable iff (!rst_n)
      fiq |-> grp0_en);

   a_r13_err_follows_access: assert property (@(posedge clk) disable iff (!rst_n)
      bus_err |-> $past(bus_wr || bus_rd));

   a_r9_err_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_err && $past(bus_rd)) |-> (bus_rdata == '0));

   for (genvar i = 0; i < NUM_PPI; i++) begin : g_line
      a_r11_line_rise: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(ppi_level[i]) |=> pend[NUM_SGI+i]);
      a_r11_line_fall: assert property (@(posedge clk) disable iff (!rst_n)
         $fell(ppi_level[i]) |=> !pend[NUM_SGI+i]);
   end

endmodule

bind pirq_redist pirq_redist_chk #(.NUM_SGI(NUM_SGI), .NUM_PPI(NUM_PPI)) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_err(bus_err),
   .bus_rdata(bus_rdata), .ppi_level(ppi_level), .grp0_en(grp0_en), .grp1_en(grp1_en),
   .irq(irq), .fiq(fiq), .en(en_map), .pend(pend_map), .act(act_map)
);

// File: tb/pirq_redist_test.sv
module pirq_redist_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [23:0] bus_addr = '0;
   logic        bus_wr = 1'b0, bus_rd = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        bus_err;
   logic [15:0] ppi_level = '0;
   logic [3:0]  sgi_id = '0;
   logic        sgi_set = 1'b0, sgi_clr = 1'b0;
   logic        grp0_en = 1'b1, grp1_en = 1'b1;
   logic        irq, fiq;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   always #10 clk = ~clk;   // 50 MHz

   pirq_redist #(.SELF_ID(1)) uut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_err(bus_err),
      .ppi_level(ppi_level), .sgi_id(sgi_id), .sgi_set(sgi_set), .sgi_clr(sgi_clr),
      .grp0_en(grp0_en), .grp1_en(grp1_en), .irq(irq), .fiq(fiq)
   );

   // slot 1: control frame at 0x20000, private frame at 0x30000
   localparam logic [23:0] GRP = 24'h30000, ENS = 24'h30010, ENC = 24'h30014;
   localparam logic [23:0] PNS = 24'h30020, PNC = 24'h30024;
   localparam logic [23:0] ACS = 24'h30030, ACC = 24'h30034;
   localparam logic [23:0] PRI = 24'h30040, CF1 = 24'h30084;

   typedef struct packed {
      logic        rd;
      logic [23:0] addr;
      logic [31:0] data;
      logic        irq;
      logic        fiq;
      logic [3:0]  req;
   } vec_t;

   localparam int NV = 25;
   localparam vec_t VECS [NV] = '{
      '{1'b1, ENS,        32'h0,        1'b0, 1'b0, 4'd13}, // R13 reset state
      '{1'b0, ENS,        32'h000000F0, 1'b0, 1'b0, 4'd1},  // R1
      '{1'b1, ENC,        32'h000000F0, 1'b0, 1'b0, 4'd2},  // R2
      '{1'b0, ENS,        32'h0,        1'b0, 1'b0, 4'd1},  // R1 zero write
      '{1'b1, ENS,        32'h000000F0, 1'b0, 1'b0, 4'd1},
      '{1'b0, PNS,        32'h00000010, 1'b0, 1'b1, 4'd4},  // R4 group 0
      '{1'b0, GRP,        32'h00000010, 1'b1, 1'b0, 4'd3},  // R3 group 1
      '{1'b1, GRP,        32'h00000010, 1'b1, 1'b0, 4'd7},  // R7
      '{1'b0, ACS,        32'h00000010, 1'b0, 1'b0, 4'd5},  // R5 active excluded
      '{1'b1, ACC,        32'h00000010, 1'b0, 1'b0, 4'd2},  // R2
      '{1'b0, ACC,        32'h00000010, 1'b1, 1'b0, 4'd1},
      '{1'b0, PNS,        32'h00000020, 1'b1, 1'b1, 4'd4},  // both lines
      '{1'b0, ENC,        32'h00000010, 1'b0, 1'b1, 4'd1},
      '{1'b0, PNC,        32'h00000020, 1'b0, 1'b0, 4'd5},  // pending not enabled
      '{1'b1, PNS,        32'h00000010, 1'b0, 1'b0, 4'd1},
      '{1'b0, PRI+24'h4,  32'hA1B2C3D4, 1'b0, 1'b0, 4'd6},  // R6
      '{1'b1, PRI+24'h4,  32'hA1B2C3D4, 1'b0, 1'b0, 4'd6},
      '{1'b0, PRI+24'h1C, 32'h11223344, 1'b0, 1'b0, 4'd6},
      '{1'b1, PRI+24'h1C, 32'h11223344, 1'b0, 1'b0, 4'd6},
      '{1'b1, PRI,        32'h0,        1'b0, 1'b0, 4'd6},
      '{1'b0, CF1,        32'h5555AAAA, 1'b0, 1'b0, 4'd7},
      '{1'b1, CF1,        32'h5555AAAA, 1'b0, 1'b0, 4'd7},
      '{1'b0, 24'h30013,  32'h00000001, 1'b0, 1'b0, 4'd10}, // R10 unaligned
      '{1'b1, ENS,        32'h000000E1, 1'b0, 1'b0, 4'd10},
      '{1'b0, PNS,        32'h00000001, 1'b0, 1'b1, 4'd4}
   };

   task automatic chk(input int req, input string what, input logic [31:0] got, input logic [31:0] exp);
      n_tests++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL R%0d %s: actual %h expected %h", req, what, got, exp);
      end
   endtask

   task automatic acc(input logic rd, input logic [23:0] a, input logic [31:0] d);
      bus_addr  = a;
      bus_rd    = rd;
      bus_wr    = !rd;
      bus_wdata = d;
      @(negedge clk);
      bus_rd = 1'b0;
      bus_wr = 1'b0;
   endtask

   task automatic rd_chk(input int req, input logic [23:0] a, input logic [31:0] exp, input logic exp_err);
      acc(1'b1, a, '0);
      chk(req, "rdata", bus_rdata, exp);
      chk(req, "err", 32'(bus_err), 32'(exp_err));
   endtask

   initial begin
      #(20 * 200000);
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL R13 watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(13, "irq after reset", 32'(irq), 0);
      chk(13, "fiq after reset", 32'(fiq), 0);

      for (int i = 0; i < NV; i++) begin
         acc(VECS[i].rd, VECS[i].addr, VECS[i].data);
         if (VECS[i].rd) chk(int'(VECS[i].req), "table rdata", bus_rdata, VECS[i].data);
         chk(int'(VECS[i].req), "table irq", 32'(irq), 32'(VECS[i].irq));
         chk(int'(VECS[i].req), "table fiq", 32'(fiq), 32'(VECS[i].fiq));
         chk(9, "table no err", 32'(bus_err), 0);
      end
      // state now: en E1, pend 11, act 0, grp 10

      // R9 control frame and unmapped offset
      acc(1'b0, 24'h20010, 32'hFFFFFFFF);
      chk(9, "ctrl write err", 32'(bus_err), 1);
      @(negedge clk);
      chk(9, "err one cycle", 32'(bus_err), 0);
      rd_chk(9, ENS, 32'hE1, 1'b0);
      rd_chk(9, 24'h2FFF0, 32'h0, 1'b1);
      rd_chk(9, 24'h30100, 32'h0, 1'b1);

      // R8 foreign slot
      acc(1'b0, 24'h10010, 32'hFFFFFFFF);
      chk(8, "foreign write err", 32'(bus_err), 0);
      rd_chk(8, 24'h10010, 32'h0, 1'b0);
      rd_chk(8, ENS, 32'hE1, 1'b0);

      // R11 peripheral line edges
      ppi_level = 16'h0004;
      @(negedge clk);
      rd_chk(11, PNS, 32'h00040011, 1'b0);
      acc(1'b0, PNC, 32'h00040000);
      @(negedge clk);
      rd_chk(11, PNS, 32'h00000011, 1'b0);   // held level does not re-pend
      ppi_level = 16'h0000;
      @(negedge clk);
      ppi_level = 16'h0004;
      @(negedge clk);
      ppi_level = 16'h0000;
      @(negedge clk);
      rd_chk(11, PNS, 32'h00000011, 1'b0);   // falling edge clears

      // R12 software interrupt strobes
      sgi_id  = 4'd3;
      sgi_set = 1'b1;
      @(negedge clk);
      sgi_set = 1'b0;
      rd_chk(12, PNS, 32'h00000019, 1'b0);
      sgi_set = 1'b1;
      sgi_clr = 1'b1;
      @(negedge clk);
      sgi_set = 1'b0;
      sgi_clr = 1'b0;
      rd_chk(12, PNS, 32'h00000011, 1'b0);

      // R4 group-0 enable gates fiq; R3 group flip moves it to irq
      chk(4, "fiq before gate", 32'(fiq), 1);
      grp0_en = 1'b0;
      #1;
      chk(4, "fiq gated", 32'(fiq), 0);
      @(negedge clk);
      acc(1'b0, GRP, 32'h00000001);
      chk(3, "irq after group flip", 32'(irq), 1);
      grp1_en = 1'b0;
      #1;
      chk(3, "irq gated", 32'(irq), 0);
      @(negedge clk);

      // R13 reset clears everything
      grp0_en = 1'b1;
      grp1_en = 1'b1;
      rst_n   = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(13, "irq after re-reset", 32'(irq), 0);
      chk(13, "fiq after re-reset", 32'(fiq), 0);
      rd_chk(13, ENS, 32'h0, 1'b0);
      rd_chk(13, PRI + 24'h4, 32'h0, 1'b0);

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule